// File: doc/BRIEF.md
# Packet Page Allocation Unit

This block keeps track of a small pool of fixed-size packet pages (four pages of 2048 bytes by default) for a network controller. Only page numbers pass through it; the packet memory, the frame engine and the host register file sit elsewhere. It holds an allocation bitmap and three short FIFOs of page numbers: one for pages waiting to be transmitted, one for pages whose transmission has completed, and one for received frames waiting for the host.

The host issues commands by writing a byte whose top three bits select an operation. The receive engine raises a request for each incoming frame and is given the lowest free page, if any. An allocation for transmit that finds the pool full is left pending. It completes by itself on the next page release. The outputs feed an interrupt block and the host readback logic: the allocation result, the two readable queue heads, a count of pages in use, and level events for allocation done, receive pending and transmit done.

Each clock cycle has a single slot for work. A host command takes the slot first. Otherwise, while transmit is enabled, one transmit page is sent. Otherwise a receive request is served.

Top module: `pba_alloc_unit`

## Requirements
- R1: After reset, alloc_result is 0, alloc_done, rx_pending, tx_done and rx_ok are 0, used_count and tx_count are 0, and both rx_head and done_head read 0x80.
- R2: Command byte bits [7:5] select the operation. Code 1 (allocate) takes the lowest-numbered free page, sets its bitmap bit, puts its number on alloc_result and sets alloc_done one cycle later. used_count is always the number of set bitmap bits.
- R3: An allocate command that finds all pages taken sets alloc_result to 0x80 and clears alloc_done.
- R4: While alloc_result is 0x80, any page release retries the allocation in the same cycle. The retry takes the lowest free page and sets alloc_done.
- R5: An accepted receive request takes the lowest free page, appends it to the receive queue, sets rx_pending and pulses rx_ok for one cycle. If the pool is full or the receive queue already holds 4 entries, nothing changes and rx_ok stays 0. rx_head shows the oldest entry, or 0x80 when the queue is empty.
- R6: Code 3 removes the receive head and leaves its page allocated. Code 4 removes the receive head and frees its page. After either one, rx_pending is 1 only if entries remain. Neither has any effect on an empty queue.
- R7: Code 5 frees the page given on pkt_num.
- R8: Code 6 appends pkt_num to the transmit queue. The write is ignored when that queue holds 4 entries. tx_count shows the queue length.
- R9: While transmit is enabled and no command is present, one transmit page leaves the head of the queue each cycle, in order. With auto_release set, the page is freed. Otherwise its number is appended to the completion queue if that queue has room. done_head shows the oldest completion, or 0x80 when none.
- R10: done_ack removes the completion head. If a completion is added in the same cycle, the removal happens first. tx_done is 1 while the completion queue is not empty.
- R11: Code 7 empties the transmit and completion queues. Code 2 frees all pages, empties all three queues, clears rx_pending and sets alloc_result to 0. Code 0 has no effect.
- R12: A command has priority over a transmit drain, which has priority over a receive request. rx_ack is high in the cycle a receive request is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command byte present this cycle |
| cmd_byte | input | 8 | Command byte, operation in bits [7:5] |
| pkt_num | input | 2 | Page number used by release and transmit queueing |
| tx_enable | input | 1 | Allows the transmit queue to drain |
| auto_release | input | 1 | Free sent pages instead of recording completions |
| rx_req | input | 1 | Receive engine asks for a page |
| done_ack | input | 1 | Removes the completion queue head |
| rx_ack | output | 1 | Receive request served this cycle |
| rx_ok | output | 1 | One-cycle pulse: previous served request got a page |
| alloc_result | output | 8 | Last transmit allocation result, 0x80 when failed or pending |
| alloc_done | output | 1 | Allocation-done event level |
| rx_pending | output | 1 | Receive-pending event level |
| tx_done | output | 1 | Completion queue not empty |
| rx_head | output | 8 | Oldest receive page, 0x80 when empty |
| done_head | output | 8 | Oldest completed page, 0x80 when empty |
| used_count | output | 3 | Number of allocated pages |
| tx_count | output | 3 | Transmit queue length |

## Verification
Every result except rx_ack comes from a register. A command, drain or receive request applied before a rising edge therefore shows on the outputs right after that edge. The one exception is rx_ok, which reports a served request during the following cycle. rx_ack is combinational from the inputs and the current transmit length, so the bench samples it in the same cycle, before the edge. Registered outputs are sampled one nanosecond after the edge and compared against a model that the bench advances by one step for each edge.

// File: rtl/pba_pkg.sv
package pba_pkg;

  localparam logic [7:0] PBA_EMPTY = 8'h80;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_ALLOC   = 3'd1,
    OP_RESET   = 3'd2,
    OP_RX_POP  = 3'd3,
    OP_RX_FREE = 3'd4,
    OP_RELEASE = 3'd5,
    OP_TX_PUSH = 3'd6,
    OP_TX_CLR  = 3'd7
  } pba_op_e;

  typedef enum logic [1:0] {
    SLOT_IDLE,
    SLOT_CMD,
    SLOT_DRAIN,
    SLOT_RX
  } pba_slot_e;

endpackage

// File: rtl/pba_queue.sv
module pba_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 2,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count
);

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  ent_q [DEPTH];
  logic [W-1:0]  ent_n [DEPTH];
  logic [CW-1:0] cnt_q, cnt_n;
  logic          upd;

  assign upd = clr | push | pop;

  always_comb begin
    ent_n = ent_q;
    cnt_n = cnt_q;
    if (clr) begin
      cnt_n = '0;
    end else begin
      if (pop && cnt_q != '0) begin
        for (int i = 0; i < DEPTH - 1; i++) begin
          ent_n[i] = ent_q[i+1];
        end
        cnt_n = cnt_q - CW'(1);
      end
      if (push && cnt_n < FULL) begin
        ent_n[cnt_n[AW-1:0]] = push_data;
        cnt_n = cnt_n + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        ent_q[i] <= '0;
      end
    end else if (upd) begin
      cnt_q <= cnt_n;
      ent_q <= ent_n;
    end
  end

  assign head  = ent_q[0];
  assign count = cnt_q;

  AST_Q_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL); // R8

  AST_Q_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == FULL && push && !pop && !clr) |=> (cnt_q == FULL)); // R8

endmodule

// File: rtl/pba_pool.sv
module pba_pool #(
  parameter int PAGES = 4,
  localparam int PW   = $clog2(PAGES),
  localparam int CW   = $clog2(PAGES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          rel_en,
  input  logic [PW-1:0] rel_page,
  input  logic          alloc_en,
  output logic          grant,
  output logic [PW-1:0] grant_page,
  output logic [CW-1:0] used_count
);

  logic [PAGES-1:0] bm_q, bm_n, bm_rel;
  logic             any_free;
  logic [PW-1:0]    free_idx;
  logic             upd;

  always_comb begin
    bm_rel = bm_q;
    if (rel_en) begin
      bm_rel[rel_page] = 1'b0;
    end
  end

  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = PAGES - 1; i >= 0; i--) begin
      if (!bm_rel[i]) begin
        any_free = 1'b1;
        free_idx = PW'(i);
      end
    end
  end

  assign grant      = alloc_en & any_free;
  assign grant_page = free_idx;

  always_comb begin
    bm_n = bm_rel;
    if (grant) begin
      bm_n[free_idx] = 1'b1;
    end
    if (clr) begin
      bm_n = '0;
    end
  end

  assign upd = clr | rel_en | grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bm_q <= '0;
    end else if (upd) begin
      bm_q <= bm_n;
    end
  end

  always_comb begin
    used_count = '0;
    for (int i = 0; i < PAGES; i++) begin
      used_count = used_count + CW'(bm_q[i]);
    end
  end

  AST_GRANT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !clr) |=> bm_q[$past(grant_page)]); // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !clr && !rel_en) |=> (used_count == $past(used_count) + CW'(1))); // R2

endmodule

// File: rtl/pba_alloc_unit.sv
module pba_alloc_unit
  import pba_pkg::*;
#(
  parameter int PAGES  = 4,
  parameter int QDEPTH = 4,
  localparam int PW    = $clog2(PAGES),
  localparam int CW    = $clog2(PAGES + 1),
  localparam int QCW   = $clog2(QDEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  input  logic [7:0]     cmd_byte,
  input  logic [PW-1:0]  pkt_num,
  input  logic           tx_enable,
  input  logic           auto_release,
  input  logic           rx_req,
  input  logic           done_ack,
  output logic           rx_ack,
  output logic           rx_ok,
  output logic [7:0]     alloc_result,
  output logic           alloc_done,
  output logic           rx_pending,
  output logic           tx_done,
  output logic [7:0]     rx_head,
  output logic [7:0]     done_head,
  output logic [CW-1:0]  used_count,
  output logic [QCW-1:0] tx_count
);

  localparam logic [QCW-1:0] QFULL = QCW'(QDEPTH);
  localparam logic [CW-1:0]  PFULL = CW'(PAGES);

  pba_op_e   op;
  pba_slot_e slot;

  logic [7:0]     res_q, res_n;
  logic           adone_q, adone_n;
  logic           pend_q, pend_n;
  logic           rxok_q, rxok_n;

  logic           pool_clr, rel_en, alloc_en, grant, try_tx;
  logic [PW-1:0]  rel_page, grant_page;

  logic           rx_push, rx_pop, rx_clr;
  logic           tx_push, tx_pop, tx_clr;
  logic           dn_push, dn_pop, dn_clr;
  logic [PW-1:0]  rx_hd, tx_hd, dn_hd;
  logic [QCW-1:0] rx_cnt, tx_cnt, dn_cnt;

  assign op = pba_op_e'(cmd_byte[7:5]);

  always_comb begin
    if (cmd_valid)                        slot = SLOT_CMD;
    else if (tx_enable && tx_cnt != '0)   slot = SLOT_DRAIN;
    else if (rx_req)                      slot = SLOT_RX;
    else                                  slot = SLOT_IDLE;
  end

  assign rx_ack = (slot == SLOT_RX);

  // command, drain and receive decode
  always_comb begin
    pool_clr = 1'b0;
    rel_en   = 1'b0;
    rel_page = '0;
    alloc_en = 1'b0;
    try_tx   = 1'b0;
    rx_push  = 1'b0;
    rx_pop   = 1'b0;
    rx_clr   = 1'b0;
    tx_push  = 1'b0;
    tx_pop   = 1'b0;
    tx_clr   = 1'b0;
    dn_push  = 1'b0;
    dn_clr   = 1'b0;
    res_n    = res_q;
    adone_n  = adone_q;
    pend_n   = pend_q;
    rxok_n   = 1'b0;
    unique case (slot)
      SLOT_CMD: begin
        unique case (op)
          OP_ALLOC:   try_tx = 1'b1;
          OP_RESET: begin
            pool_clr = 1'b1;
            rx_clr   = 1'b1;
            tx_clr   = 1'b1;
            dn_clr   = 1'b1;
            res_n    = 8'h00;
            pend_n   = 1'b0;
          end
          OP_RX_POP: begin
            rx_pop = (rx_cnt != '0);
            pend_n = (rx_cnt > QCW'(1));
          end
          OP_RX_FREE: begin
            rx_pop   = (rx_cnt != '0);
            rel_en   = (rx_cnt != '0);
            rel_page = rx_hd;
            pend_n   = (rx_cnt > QCW'(1));
          end
          OP_RELEASE: begin
            rel_en   = 1'b1;
            rel_page = pkt_num;
          end
          OP_TX_PUSH: tx_push = 1'b1;
          OP_TX_CLR: begin
            tx_clr = 1'b1;
            dn_clr = 1'b1;
          end
          default: ;
        endcase
      end
      SLOT_DRAIN: begin
        tx_pop = 1'b1;
        if (auto_release) begin
          rel_en   = 1'b1;
          rel_page = tx_hd;
        end else begin
          dn_push = 1'b1;
        end
      end
      SLOT_RX: begin
        alloc_en = (rx_cnt != QFULL);
        if (grant) begin
          rx_push = 1'b1;
          pend_n  = 1'b1;
          rxok_n  = 1'b1;
        end
      end
      default: ;
    endcase
    // a release while a transmit allocation is pending retries it
    if (rel_en && res_q == PBA_EMPTY) begin
      try_tx = 1'b1;
    end
    if (try_tx) begin
      alloc_en = 1'b1;
      if (grant) begin
        res_n   = 8'(grant_page);
        adone_n = 1'b1;
      end else begin
        res_n   = PBA_EMPTY;
        adone_n = 1'b0;
      end
    end
  end

  assign dn_pop = done_ack & (dn_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= 8'h00;
      adone_q <= 1'b0;
      pend_q  <= 1'b0;
      rxok_q  <= 1'b0;
    end else begin
      if (try_tx || pool_clr) begin
        res_q   <= res_n;
        adone_q <= adone_n;
      end
      if (rx_push || rx_pop || rx_clr || slot == SLOT_CMD) begin
        pend_q <= pend_n;
      end
      rxok_q <= rxok_n;
    end
  end

  pba_pool #(.PAGES(PAGES)) u_pool (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (pool_clr),
    .rel_en     (rel_en),
    .rel_page   (rel_page),
    .alloc_en   (alloc_en),
    .grant      (grant),
    .grant_page (grant_page),
    .used_count (used_count)
  );

  pba_queue #(.DEPTH(QDEPTH), .W(PW)) u_rxq (
    .clk (clk), .rst_n (rst_n), .clr (rx_clr), .push (rx_push),
    .push_data (grant_page), .pop (rx_pop), .head (rx_hd), .count (rx_cnt)
  );

  pba_queue #(.DEPTH(QDEPTH), .W(PW)) u_txq (
    .clk (clk), .rst_n (rst_n), .clr (tx_clr), .push (tx_push),
    .push_data (pkt_num), .pop (tx_pop), .head (tx_hd), .count (tx_cnt)
  );

  pba_queue #(.DEPTH(QDEPTH), .W(PW)) u_dnq (
    .clk (clk), .rst_n (rst_n), .clr (dn_clr), .push (dn_push),
    .push_data (tx_hd), .pop (dn_pop), .head (dn_hd), .count (dn_cnt)
  );

  assign alloc_result = res_q;
  assign alloc_done   = adone_q;
  assign rx_pending   = pend_q;
  assign rx_ok        = rxok_q;
  assign tx_done      = (dn_cnt != '0);
  assign tx_count     = tx_cnt;
  assign rx_head      = (rx_cnt == '0) ? PBA_EMPTY : 8'(rx_hd);
  assign done_head    = (dn_cnt == '0) ? PBA_EMPTY : 8'(dn_hd);

  AST_ALLOC_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op == OP_ALLOC && used_count == PFULL)
      |=> (alloc_result == PBA_EMPTY && !alloc_done)); // R3

  AST_RETRY_ON_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_en && alloc_result == PBA_EMPTY)
      |=> (alloc_result != PBA_EMPTY && alloc_done)); // R4

  AST_RX_LAST_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op == OP_RX_POP && rx_cnt == QCW'(1))
      |=> (!rx_pending && rx_head == PBA_EMPTY)); // R6

  AST_TX_FULL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op == OP_TX_PUSH && tx_cnt == QFULL)
      |=> (tx_count == QFULL)); // R8

  AST_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_ack, cmd_valid, tx_pop})); // R12

endmodule

// File: tb/pba_alloc_unit_tb.sv
module pba_alloc_unit_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid;
  logic [7:0] cmd_byte;
  logic [1:0] pkt_num;
  logic       tx_enable, auto_release, rx_req, done_ack;
  logic       rx_ack, rx_ok, alloc_done, rx_pending, tx_done;
  logic [7:0] alloc_result, rx_head, done_head;
  logic [2:0] used_count, tx_count;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  int m_bm, m_res, m_adone, m_pend, m_rxok;
  int m_rxq[$];
  int m_txq[$];
  int m_dq[$];

  always #4 clk = ~clk;

  pba_alloc_unit u_dut (
    .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_byte (cmd_byte),
    .pkt_num (pkt_num), .tx_enable (tx_enable), .auto_release (auto_release),
    .rx_req (rx_req), .done_ack (done_ack), .rx_ack (rx_ack), .rx_ok (rx_ok),
    .alloc_result (alloc_result), .alloc_done (alloc_done),
    .rx_pending (rx_pending), .tx_done (tx_done), .rx_head (rx_head),
    .done_head (done_head), .used_count (used_count), .tx_count (tx_count)
  );

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int lowest_free(int bm);
    for (int i = 0; i < 4; i++) if (!bm[i]) return i;
    return -1;
  endfunction

  function automatic int popc(int bm);
    int n = 0;
    for (int i = 0; i < 4; i++) n += bm[i];
    return n;
  endfunction

  task automatic m_release(int p);
    int q;
    m_bm &= ~(1 << p);
    if (m_res == 128) begin
      q = lowest_free(m_bm);
      m_bm |= (1 << q);
      m_res = q;
      m_adone = 1;
    end
  endtask

  task automatic m_step(bit cv, logic [7:0] b, int pk, bit txe, bit ar, bit rq, bit ack);
    int p;
    int h;
    m_rxok = 0;
    if (ack && m_dq.size() > 0) void'(m_dq.pop_front());
    if (cv) begin
      case (b[7:5])
        3'd1: begin
          p = lowest_free(m_bm);
          if (p >= 0) begin m_bm |= (1 << p); m_res = p; m_adone = 1; end
          else begin m_res = 128; m_adone = 0; end
        end
        3'd2: begin
          m_bm = 0; m_rxq.delete(); m_txq.delete(); m_dq.delete();
          m_res = 0; m_pend = 0;
        end
        3'd3: begin
          if (m_rxq.size() > 0) void'(m_rxq.pop_front());
          m_pend = (m_rxq.size() > 0);
        end
        3'd4: begin
          if (m_rxq.size() > 0) begin h = m_rxq.pop_front(); m_release(h); end
          m_pend = (m_rxq.size() > 0);
        end
        3'd5: m_release(pk);
        3'd6: if (m_txq.size() < 4) m_txq.push_back(pk);
        3'd7: begin m_txq.delete(); m_dq.delete(); end
        default: ;
      endcase
    end else if (txe && m_txq.size() > 0) begin
      h = m_txq.pop_front();
      if (ar) m_release(h);
      else if (m_dq.size() < 4) m_dq.push_back(h);
    end else if (rq) begin
      p = lowest_free(m_bm);
      if (p >= 0 && m_rxq.size() < 4) begin
        m_bm |= (1 << p); m_rxq.push_back(p); m_pend = 1; m_rxok = 1;
      end
    end
  endtask

  task automatic compare_all();
    chk("R2", "alloc_result", alloc_result, m_res);
    chk("R2", "used_count", used_count, popc(m_bm));
    chk("R3", "alloc_done", alloc_done, m_adone);
    chk("R5", "rx_head", rx_head, (m_rxq.size() > 0) ? m_rxq[0] : 128);
    chk("R5", "rx_ok", rx_ok, m_rxok);
    chk("R6", "rx_pending", rx_pending, m_pend);
    chk("R8", "tx_count", tx_count, m_txq.size());
    chk("R9", "done_head", done_head, (m_dq.size() > 0) ? m_dq[0] : 128);
    chk("R10", "tx_done", tx_done, m_dq.size() > 0);
  endtask

  // drive after a falling edge, check rx_ack before the rising edge,
  // check registered outputs 1 ns after it
  task automatic step(bit cv, logic [7:0] b, int pk, bit txe, bit ar, bit rq, bit ack);
    cmd_valid = cv; cmd_byte = b; pkt_num = 2'(pk); tx_enable = txe;
    auto_release = ar; rx_req = rq; done_ack = ack;
    #1;
    chk("R12", "rx_ack", rx_ack, rq && !cv && !(txe && m_txq.size() > 0));
    m_step(cv, b, pk, txe, ar, rq, ack);
    @(posedge clk);
    #1;
    compare_all();
    @(negedge clk);
  endtask

  task automatic cmd(logic [7:0] b, int pk);
    step(1, b, pk, 0, 0, 0, 0);
  endtask

  task automatic idle(bit txe, bit ar);
    step(0, 8'h00, 0, txe, ar, 0, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    cmd_valid = 0; cmd_byte = 0; pkt_num = 0; tx_enable = 0;
    auto_release = 0; rx_req = 0; done_ack = 0;
    m_bm = 0; m_res = 0; m_adone = 0; m_pend = 0; m_rxok = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1", "alloc_result", alloc_result, 0);
    chk("R1", "rx_head", rx_head, 8'h80);
    chk("R1", "done_head", done_head, 8'h80);
    chk("R1", "used_count", used_count, 0);
    chk("R1", "alloc_done", alloc_done, 0);
    chk("R1", "rx_pending", rx_pending, 0);
    chk("R1", "tx_done", tx_done, 0);
    @(negedge clk);

    // R2 lowest-first allocation
    for (int i = 0; i < 4; i++) begin
      cmd(8'h20, 0);
      chk("R2", "alloc page", alloc_result, i);
      chk("R2", "used pages", used_count, i + 1);
    end
    // R3 pool full
    cmd(8'h3F, 0);
    chk("R3", "full result", alloc_result, 8'h80);
    chk("R3", "full done", alloc_done, 0);
    // R5 receive refused when full
    step(0, 8'h00, 0, 0, 0, 1, 0);
    chk("R5", "refused rx_ok", rx_ok, 0);
    // R7 + R4 release page 2 retries pending allocation
    cmd(8'hA0, 2);
    chk("R4", "retry result", alloc_result, 2);
    chk("R4", "retry done", alloc_done, 1);
    chk("R7", "used after release", used_count, 4);
    cmd(8'hA0, 1);
    chk("R7", "used after free", used_count, 3);
    // R11 unit reset
    cmd(8'h40, 0);
    chk("R11", "reset used", used_count, 0);
    chk("R11", "reset result", alloc_result, 0);
    // R5 receive fills pages 0,1
    step(0, 8'h00, 0, 0, 0, 1, 0);
    chk("R5", "rx_ok", rx_ok, 1);
    step(0, 8'h00, 0, 0, 0, 1, 0);
    chk("R5", "rx head", rx_head, 0);
    // R12 command beats receive request
    step(1, 8'h20, 0, 0, 0, 1, 0);
    chk("R12", "cmd won", alloc_result, 2);
    // R6 pop keeps page, pop-free frees it
    cmd(8'h60, 0);
    chk("R6", "head after pop", rx_head, 1);
    chk("R6", "pending kept", rx_pending, 1);
    cmd(8'h80, 0);
    chk("R6", "head empty", rx_head, 8'h80);
    chk("R6", "pending cleared", rx_pending, 0);
    chk("R6", "used after pop-free", used_count, 2);
    // R8 full transmit queue ignores writes
    for (int i = 0; i < 5; i++) cmd(8'hC0, 2);
    chk("R8", "tx full", tx_count, 4);
    // R9 drain into completion queue
    for (int i = 0; i < 4; i++) idle(1, 0);
    chk("R9", "tx drained", tx_count, 0);
    chk("R9", "done head", done_head, 2);
    chk("R10", "tx_done", tx_done, 1);
    // R10 acknowledge
    step(0, 8'h00, 0, 0, 0, 0, 1);
    chk("R10", "still done", tx_done, 1);
    // R11 clear queues
    cmd(8'hE0, 0);
    chk("R11", "done cleared", done_head, 8'h80);
    // R9 auto release
    cmd(8'hC0, 2);
    idle(1, 1);
    chk("R9", "auto freed", used_count, 1);
    // R11 code 0 has no effect
    cmd(8'h1F, 3);
    chk("R11", "nop used", used_count, 1);

    // random traffic against the model
    for (int k = 0; k < 4000; k++) begin
      step(($urandom % 3) == 0, 8'($urandom), $urandom % 4, ($urandom % 4) == 0,
           $urandom % 2, ($urandom % 3) == 0, ($urandom % 5) == 0);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule